// File: doc/BRIEF.md
# Dual-View Security Register Bank

This block is the register file of a chip security controller. One set of state is reached through two 4 KB address windows. The secure window (`busSecure` high) holds every setting: the callable-region configuration, the security response setting, the interrupt enables and clears for the protection checkers, and the non-secure and secure-privilege masks of every peripheral protection controller (PPC). The non-secure window (`busSecure` low) shows only the non-secure-privilege masks and a set of identification bytes. Every other location in that window reads as zero and is rejected.

The bus is a simple single-cycle request: valid, write, window select, 12-bit byte address, a size code and 32-bit write data. A read returns its data one cycle after the request. The block fetches the aligned word and then returns the byte or halfword lane that the low address bits select. Only full-word writes change state. Narrow writes, writes to read-only locations, reads of write-only locations and accesses to unmapped offsets raise a one-cycle error flag and change nothing. The stored settings drive the configuration outputs directly. Each PPC port also gets a privilege output, taken from the non-secure-privilege mask when the port is marked non-secure and from the secure-privilege mask otherwise.

Top module: `secbank_top`

## Requirements
- R1: A synchronous active-low reset clears every stored register. While reset is low, and on the first cycle after it, all outputs are zero, including `rdValid` and `accErr`.
- R2: Only a write with size code 2 or 3 (`busSize[1]` = 1) updates state. A write with size code 0 (byte) or 1 (halfword) changes nothing and raises `accErr` in the next cycle.
- R3: A read is answered in the next cycle with `rdValid` high. `rdData` is the aligned word shifted right by 8 × `busAddr[1:0]`, then masked to 8 bits (size code 0), 16 bits (code 1) or 32 bits (codes 2 and 3). A write never raises `rdValid`.
- R4: Secure offset 0x000 keeps only bits [1:0] of a write. Those bits drive `cfgCallable` from the cycle after the write.
- R5: Secure offset 0x010 stores all 32 bits. Its bit 0 drives `respErrEn`.
- R6: Secure offset 0x028 keeps only the bits in mask 0x00F000F3 and drives `ppcIntEn`. Secure offset 0x048 keeps only bits [31:16].
- R7: Secure offsets 0x01C and 0x020 read `mpcStatIn` and `ppcStatIn` as sampled at the request edge. A write to either is ignored and raises `accErr`.
- R8: A full-word write to secure offset 0x024 drives its data on `ppcIntClr` for exactly one cycle, the cycle after the write. A read of 0x024 returns zero and raises `accErr`.
- R9: PPCs have a flat index: expansion-AHB instances i = 0..3 are indices 0..3, APB instances i = 0..1 are indices 4..5, and expansion-APB instances i = 0..3 are indices 6..9. In the secure window the non-secure masks sit at 0x060+4i, 0x070+4i and 0x080+4i, and the secure-privilege masks sit at 0x0A0+4i, 0x0B0+4i and 0x0C0+4i. Each mask keeps its low `PORTS` bits. Mask bit k of PPC j appears on output bit j·`PORTS`+k of `ppcNonSec`. An instance slot beyond the count (for example 0x078) is unmapped.
- R10: The non-secure window maps the non-secure-privilege masks at 0x0A0+4i, 0x0B0+4i and 0x0C0+4i, with the same instance layout. All secure-only registers are absent there: they read as zero, raise `accErr` and cannot be written.
- R11: Each `ppcPriv` bit equals the non-secure-privilege bit when the matching `ppcNonSec` bit is 1, and the secure-privilege bit otherwise.
- R12: Both windows hold read-only identification words at 0xFD0..0xFFC, one byte per word, in this order: 04,00,00,00,52,B8,0B,00,0D,F0,05,B1. The non-secure window differs only at 0xFE0, which reads 0x53. Writes to these words raise `accErr` and change nothing.
- R13: An unmapped offset reads as zero and raises `accErr` for one cycle. A write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSecure | input | 1 | 1 = secure window, 0 = non-secure window |
| busAddr | input | 12 | Byte offset inside the window |
| busSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| busWdata | input | 32 | Write data |
| mpcStatIn | input | 32 | Memory-checker interrupt status, read at 0x01C |
| ppcStatIn | input | 32 | PPC interrupt status, read at 0x020 |
| rdValid | output | 1 | Read data valid, one cycle after the read request |
| rdData | output | 32 | Read data, lane-selected and size-masked |
| accErr | output | 1 | One-cycle flag for a rejected access |
| cfgCallable | output | 2 | Callable-region configuration |
| respErrEn | output | 1 | Security response setting, bit 0 |
| ppcIntEn | output | 32 | PPC interrupt enables |
| ppcIntClr | output | 32 | One-cycle PPC interrupt clear pulse |
| ppcNonSec | output | NUM_PPC×PORTS | Non-secure marking per PPC port |
| ppcPriv | output | NUM_PPC×PORTS | Selected privilege per PPC port |

## Verification
Two functions of this block meet in one cycle when a secure write flips the non-secure marking of a PPC port. In that same cycle the marking output changes, and the privilege output switches its source from the secure-privilege mask to the non-secure-privilege mask. The bench provokes this by first loading the two privilege masks with different patterns through both windows, then rewriting the marking. In the cycle after that write it checks both outputs against values derived from the selection rule. A second meeting point is the one-cycle error pulse of a rejected access arriving together with the zero read data of that access. The scoreboard judges both fields of the response item in the same cycle.

// File: rtl/secbank_pkg.sv
package secbank_pkg;

  // Word-aligned byte offsets of the single registers
  localparam logic [11:0] OFF_CALLABLE = 12'h000;
  localparam logic [11:0] OFF_RESP     = 12'h010;
  localparam logic [11:0] OFF_MPCST    = 12'h01C;
  localparam logic [11:0] OFF_PPCST    = 12'h020;
  localparam logic [11:0] OFF_PPCCLR   = 12'h024;
  localparam logic [11:0] OFF_PPCEN    = 12'h028;
  localparam logic [11:0] OFF_BRGEN    = 12'h048;

  // Group numbers (address bits [11:4]) of the per-PPC masks
  localparam logic [7:0] GRP_NS_AHBX  = 8'h06;
  localparam logic [7:0] GRP_NS_APB   = 8'h07;
  localparam logic [7:0] GRP_NS_APBX  = 8'h08;
  localparam logic [7:0] GRP_PRV_AHBX = 8'h0A;
  localparam logic [7:0] GRP_PRV_APB  = 8'h0B;
  localparam logic [7:0] GRP_PRV_APBX = 8'h0C;

  // First identification word index (address bits [11:2])
  localparam logic [9:0] ID_FIRST_WORD = 10'h3F4;

  localparam logic [31:0] PPC_EN_KEEP = 32'h00F0_00F3;
  localparam logic [31:0] BRG_EN_KEEP = 32'hFFFF_0000;

  typedef enum logic [3:0] {
    RS_ZERO, RS_CALLABLE, RS_RESP, RS_MPCST, RS_PPCST,
    RS_PPCEN, RS_BRGEN, RS_NS, RS_SP, RS_NSP, RS_ID
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       wrCallable;
    logic       wrResp;
    logic       wrPpcEn;
    logic       wrBrgEn;
    logic       wrPpcClr;
    logic       wrNs;
    logic       wrSp;
    logic       wrNsp;
    logic [3:0] ppcIdx;
    rdSel_e     rdSel;
    logic [3:0] idIdx;
    logic       idSec;
    logic       rdEn;
    logic [1:0] byteOff;
    logic [1:0] sizeCode;
    logic       badAcc;
  } strobe_t;

  function automatic logic [7:0] idByte(input logic [3:0] idx, input logic secView);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = secView ? 8'h52 : 8'h53;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/secbank_ctrl.sv
module secbank_ctrl
  import secbank_pkg::*;
#(
  parameter int NUM_AHB_EXP = 4,
  parameter int NUM_APB     = 2,
  parameter int NUM_APB_EXP = 4
) (
  input  logic        busValid,
  input  logic        busWrite,
  input  logic        busSecure,
  input  logic [11:0] busAddr,
  input  logic [1:0]  busSize,
  output strobe_t     stb
);

  localparam logic [3:0] BASE_APB  = 4'(NUM_AHB_EXP);
  localparam logic [3:0] BASE_APBX = 4'(NUM_AHB_EXP + NUM_APB);

  logic [7:0]  grp;
  logic [1:0]  inst;
  logic [11:0] wordOff;
  logic        kindOk, nsGrp, privGrp;
  logic [3:0]  idx;
  logic        mapped, readOnly, writeOnly;
  rdSel_e      sel;
  logic        tCall, tResp, tEn, tBrg, tClr, tNs, tSp, tNsp;
  logic        wrOk;

  assign grp     = busAddr[11:4];
  assign inst    = busAddr[3:2];
  assign wordOff = {busAddr[11:2], 2'b00};

  // Which PPC kind the group addresses, and whether the instance exists
  always_comb begin
    kindOk = 1'b0;
    idx    = '0;
    case (grp)
      GRP_NS_AHBX, GRP_PRV_AHBX: begin
        kindOk = int'(inst) < NUM_AHB_EXP;
        idx    = 4'(inst);
      end
      GRP_NS_APB, GRP_PRV_APB: begin
        kindOk = int'(inst) < NUM_APB;
        idx    = BASE_APB + 4'(inst);
      end
      GRP_NS_APBX, GRP_PRV_APBX: begin
        kindOk = int'(inst) < NUM_APB_EXP;
        idx    = BASE_APBX + 4'(inst);
      end
      default: ;
    endcase
    nsGrp   = (grp == GRP_NS_AHBX)  || (grp == GRP_NS_APB)  || (grp == GRP_NS_APBX);
    privGrp = (grp == GRP_PRV_AHBX) || (grp == GRP_PRV_APB) || (grp == GRP_PRV_APBX);
  end

  // Location decode per window
  always_comb begin
    mapped = 1'b0; readOnly = 1'b0; writeOnly = 1'b0; sel = RS_ZERO;
    tCall = 1'b0; tResp = 1'b0; tEn = 1'b0; tBrg = 1'b0; tClr = 1'b0;
    tNs = 1'b0; tSp = 1'b0; tNsp = 1'b0;
    if (busSecure) begin
      case (wordOff)
        OFF_CALLABLE: begin mapped = 1'b1; sel = RS_CALLABLE; tCall = 1'b1; end
        OFF_RESP:     begin mapped = 1'b1; sel = RS_RESP;     tResp = 1'b1; end
        OFF_MPCST:    begin mapped = 1'b1; sel = RS_MPCST;    readOnly = 1'b1; end
        OFF_PPCST:    begin mapped = 1'b1; sel = RS_PPCST;    readOnly = 1'b1; end
        OFF_PPCCLR:   begin mapped = 1'b1; writeOnly = 1'b1;  tClr = 1'b1; end
        OFF_PPCEN:    begin mapped = 1'b1; sel = RS_PPCEN;    tEn = 1'b1; end
        OFF_BRGEN:    begin mapped = 1'b1; sel = RS_BRGEN;    tBrg = 1'b1; end
        default: ;
      endcase
      if (nsGrp && kindOk) begin
        mapped = 1'b1; sel = RS_NS; tNs = 1'b1;
      end
      if (privGrp && kindOk) begin
        mapped = 1'b1; sel = RS_SP; tSp = 1'b1;
      end
    end else if (privGrp && kindOk) begin
      mapped = 1'b1; sel = RS_NSP; tNsp = 1'b1;
    end
    if (busAddr[11:2] >= ID_FIRST_WORD) begin
      mapped = 1'b1; readOnly = 1'b1; sel = RS_ID;
    end
  end

  assign wrOk = busValid && busWrite && busSize[1] && mapped && !readOnly;

  always_comb begin
    stb            = '0;
    stb.wrCallable = wrOk && tCall;
    stb.wrResp     = wrOk && tResp;
    stb.wrPpcEn    = wrOk && tEn;
    stb.wrBrgEn    = wrOk && tBrg;
    stb.wrPpcClr   = wrOk && tClr;
    stb.wrNs       = wrOk && tNs;
    stb.wrSp       = wrOk && tSp;
    stb.wrNsp      = wrOk && tNsp;
    stb.ppcIdx     = idx;
    stb.rdSel      = (mapped && !writeOnly) ? sel : RS_ZERO;
    stb.idIdx      = busAddr[5:2] - 4'd4;
    stb.idSec      = busSecure;
    stb.rdEn       = busValid && !busWrite;
    stb.byteOff    = busAddr[1:0];
    stb.sizeCode   = busSize;
    stb.badAcc     = busValid && (!mapped
                                  || (busWrite && (readOnly || !busSize[1]))
                                  || (!busWrite && writeOnly));
  end

endmodule

// File: rtl/secbank_dp.sv
module secbank_dp
  import secbank_pkg::*;
#(
  parameter int PORTS   = 16,
  parameter int NUM_PPC = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [31:0]                busWdata,
  input  logic [31:0]                mpcStatIn,
  input  logic [31:0]                ppcStatIn,
  output logic                       rdValid,
  output logic [31:0]                rdData,
  output logic                       accErr,
  output logic [1:0]                 cfgCallable,
  output logic                       respErrEn,
  output logic [31:0]                ppcIntEn,
  output logic [31:0]                ppcIntClr,
  output logic [NUM_PPC*PORTS-1:0]   ppcNonSec,
  output logic [NUM_PPC*PORTS-1:0]   ppcPriv
);

  logic [1:0]  callableQ;
  logic [31:0] respQ, ppcEnQ, brgEnQ, clrQ, rdDataQ;
  logic        rdValidQ, errQ;
  logic [NUM_PPC-1:0][PORTS-1:0] nsQ, spQ, nspQ;
  logic [PORTS-1:0] nsSel, spSel, nspSel;
  logic [31:0] rawWord, shifted, laneWord;

  // Single registers and response path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      callableQ <= '0;
      respQ     <= '0;
      ppcEnQ    <= '0;
      brgEnQ    <= '0;
      clrQ      <= '0;
      rdDataQ   <= '0;
      rdValidQ  <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (stb.wrCallable) callableQ <= busWdata[1:0];
      if (stb.wrResp)     respQ     <= busWdata;
      if (stb.wrPpcEn)    ppcEnQ    <= busWdata & PPC_EN_KEEP;
      if (stb.wrBrgEn)    brgEnQ    <= busWdata & BRG_EN_KEEP;
      clrQ     <= stb.wrPpcClr ? busWdata : '0;
      rdDataQ  <= stb.rdEn ? laneWord : '0;
      rdValidQ <= stb.rdEn;
      errQ     <= stb.badAcc;
    end
  end

  // Per-PPC mask storage and output selection
  for (genvar g = 0; g < NUM_PPC; g++) begin : gPpc
    always_ff @(posedge clk) begin
      if (!rstN) begin
        nsQ[g]  <= '0;
        spQ[g]  <= '0;
        nspQ[g] <= '0;
      end else if (stb.ppcIdx == 4'(g)) begin
        if (stb.wrNs)  nsQ[g]  <= busWdata[PORTS-1:0];
        if (stb.wrSp)  spQ[g]  <= busWdata[PORTS-1:0];
        if (stb.wrNsp) nspQ[g] <= busWdata[PORTS-1:0];
      end
    end
    assign ppcPriv[g*PORTS +: PORTS] = (nsQ[g] & nspQ[g]) | (~nsQ[g] & spQ[g]);
  end

  always_comb begin
    nsSel  = '0;
    spSel  = '0;
    nspSel = '0;
    for (int i = 0; i < NUM_PPC; i++) begin
      if (stb.ppcIdx == 4'(i)) begin
        nsSel  = nsQ[i];
        spSel  = spQ[i];
        nspSel = nspQ[i];
      end
    end
  end

  // Word fetch, lane shift and size mask
  always_comb begin
    case (stb.rdSel)
      RS_CALLABLE: rawWord = {30'b0, callableQ};
      RS_RESP:     rawWord = respQ;
      RS_MPCST:    rawWord = mpcStatIn;
      RS_PPCST:    rawWord = ppcStatIn;
      RS_PPCEN:    rawWord = ppcEnQ;
      RS_BRGEN:    rawWord = brgEnQ;
      RS_NS:       rawWord = 32'(nsSel);
      RS_SP:       rawWord = 32'(spSel);
      RS_NSP:      rawWord = 32'(nspSel);
      RS_ID:       rawWord = {24'b0, idByte(stb.idIdx, stb.idSec)};
      default:     rawWord = '0;
    endcase
    shifted = rawWord >> {stb.byteOff, 3'b000};
    case (stb.sizeCode)
      2'd0:    laneWord = shifted & 32'h0000_00FF;
      2'd1:    laneWord = shifted & 32'h0000_FFFF;
      default: laneWord = shifted;
    endcase
  end

  assign rdValid     = rdValidQ;
  assign rdData      = rdDataQ;
  assign accErr      = errQ;
  assign cfgCallable = callableQ;
  assign respErrEn   = respQ[0];
  assign ppcIntEn    = ppcEnQ;
  assign ppcIntClr   = clrQ;
  assign ppcNonSec   = nsQ;

endmodule

// File: rtl/secbank_top.sv
module secbank_top
  import secbank_pkg::*;
#(
  parameter  int PORTS       = 16,
  parameter  int NUM_AHB_EXP = 4,
  parameter  int NUM_APB     = 2,
  parameter  int NUM_APB_EXP = 4,
  localparam int NUM_PPC     = NUM_AHB_EXP + NUM_APB + NUM_APB_EXP
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busValid,
  input  logic                     busWrite,
  input  logic                     busSecure,
  input  logic [11:0]              busAddr,
  input  logic [1:0]               busSize,
  input  logic [31:0]              busWdata,
  input  logic [31:0]              mpcStatIn,
  input  logic [31:0]              ppcStatIn,
  output logic                     rdValid,
  output logic [31:0]              rdData,
  output logic                     accErr,
  output logic [1:0]               cfgCallable,
  output logic                     respErrEn,
  output logic [31:0]              ppcIntEn,
  output logic [31:0]              ppcIntClr,
  output logic [NUM_PPC*PORTS-1:0] ppcNonSec,
  output logic [NUM_PPC*PORTS-1:0] ppcPriv
);

  strobe_t stb;

  secbank_ctrl #(
    .NUM_AHB_EXP(NUM_AHB_EXP),
    .NUM_APB    (NUM_APB),
    .NUM_APB_EXP(NUM_APB_EXP)
  ) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busSecure(busSecure),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .stb      (stb)
  );

  secbank_dp #(
    .PORTS  (PORTS),
    .NUM_PPC(NUM_PPC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busWdata   (busWdata),
    .mpcStatIn  (mpcStatIn),
    .ppcStatIn  (ppcStatIn),
    .rdValid    (rdValid),
    .rdData     (rdData),
    .accErr     (accErr),
    .cfgCallable(cfgCallable),
    .respErrEn  (respErrEn),
    .ppcIntEn   (ppcIntEn),
    .ppcIntClr  (ppcIntClr),
    .ppcNonSec  (ppcNonSec),
    .ppcPriv    (ppcPriv)
  );

endmodule

// File: rtl/secbank_chk.sv
module secbank_chk #(
  parameter int PORTS   = 16,
  parameter int NUM_PPC = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busValid,
  input logic                     busWrite,
  input logic                     busSecure,
  input logic [11:0]              busAddr,
  input logic [1:0]               busSize,
  input logic [31:0]              busWdata,
  input logic                     rdValid,
  input logic                     accErr,
  input logic [1:0]               cfgCallable,
  input logic [31:0]              ppcIntClr,
  input logic [NUM_PPC*PORTS-1:0] ppcNonSec
);

  p_narrow_wr_err_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !busSize[1]) |=> accErr);

  p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid);

  p_no_rd_on_wr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |=> !rdValid);

  p_callable_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busSecure && busAddr[11:2] == 10'd0 && busSize[1])
      |=> cfgCallable == $past(busWdata[1:0]));

  p_clr_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ppcIntClr != 32'd0) |->
      $past(busValid && busWrite && busSecure && busAddr == 12'h024 && busSize[1]));

  p_ns_window_isolated_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !busSecure) |=> ($stable(cfgCallable) && $stable(ppcNonSec)));

endmodule

bind secbank_top secbank_chk #(.PORTS(PORTS), .NUM_PPC(NUM_PPC)) u_chk (.*);

// File: tb/sim_secbank_top.sv
module sim_secbank_top;

  localparam int PORTS = 16;
  localparam int NPPC  = 10;

  logic                    clk = 1'b0;
  logic                    rstN;
  logic                    busValid, busWrite, busSecure;
  logic [11:0]             busAddr;
  logic [1:0]              busSize;
  logic [31:0]             busWdata, mpcStatIn, ppcStatIn;
  logic                    rdValid, accErr, respErrEn;
  logic [31:0]             rdData, ppcIntEn, ppcIntClr;
  logic [1:0]              cfgCallable;
  logic [NPPC*PORTS-1:0]   ppcNonSec, ppcPriv;

  always #5 clk = ~clk;

  secbank_top #(.PORTS(PORTS)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busSecure(busSecure), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .mpcStatIn(mpcStatIn), .ppcStatIn(ppcStatIn),
    .rdValid(rdValid), .rdData(rdData), .accErr(accErr),
    .cfgCallable(cfgCallable), .respErrEn(respErrEn), .ppcIntEn(ppcIntEn),
    .ppcIntClr(ppcIntClr), .ppcNonSec(ppcNonSec), .ppcPriv(ppcPriv)
  );

  typedef struct {
    bit          isRead;
    logic [31:0] data;
    bit          err;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    checks   = 0;
  int    failures = 0;
  logic  capV;

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one request per call, expected response pushed to the scoreboard
  task automatic xfer(input bit sec, input bit wr, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [31:0] ed, input bit ee, input string tag);
    item_t it;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busSecure = sec;
    busAddr = a; busSize = sz; busWdata = wd;
    it.isRead = !wr; it.data = ed; it.err = ee; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic rd(input bit sec, input logic [11:0] a, input logic [1:0] sz,
                    input logic [31:0] ed, input bit ee, input string tag);
    xfer(sec, 1'b0, a, sz, 32'h0, ed, ee, tag);
  endtask

  task automatic wr(input bit sec, input logic [11:0] a, input logic [1:0] sz,
                    input logic [31:0] wd, input bit ee, input string tag);
    xfer(sec, 1'b1, a, sz, wd, 32'h0, ee, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  // Monitor: compares the response of every captured request
  always @(posedge clk) begin
    capV = busValid && rstN;
    #2;
    if (capV) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard underflow actual=response expected=none");
      end else begin
        item_t it;
        it = expQ.pop_front();
        check32({31'b0, rdValid}, {31'b0, it.isRead}, {it.tag, " rdValid"});
        check32({31'b0, accErr}, {31'b0, it.err}, {it.tag, " accErr"});
        if (it.isRead) check32(rdData, it.data, {it.tag, " rdData"});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; busValid = 1'b0; busWrite = 1'b0; busSecure = 1'b1;
    busAddr = '0; busSize = 2'd2; busWdata = '0;
    mpcStatIn = 32'h0003_0001; ppcStatIn = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check32({31'b0, rdValid}, 32'd0, "R1 rdValid");
    check32({31'b0, accErr}, 32'd0, "R1 accErr");
    check32({30'b0, cfgCallable}, 32'd0, "R1 cfgCallable");
    check32(ppcIntEn, 32'd0, "R1 ppcIntEn");
    check32(ppcNonSec[31:0], 32'd0, "R1 ppcNonSec");
    rd(1, 12'h010, 2'd2, 32'h0, 0, "R1 resp reset");

    // R4 callable configuration
    wr(1, 12'h000, 2'd2, 32'hFFFF_FFFF, 0, "R4 write");
    idle();
    check32({30'b0, cfgCallable}, 32'd3, "R4 cfgCallable");
    rd(1, 12'h000, 2'd2, 32'h3, 0, "R4 readback");
    rd(1, 12'h000, 2'd0, 32'h3, 0, "R4 byte read");

    // R2 narrow write rejected, R5 full write
    wr(1, 12'h010, 2'd1, 32'h0000_1234, 1, "R2 half write");
    wr(1, 12'h010, 2'd0, 32'h0000_00FF, 1, "R2 byte write");
    rd(1, 12'h010, 2'd2, 32'h0, 0, "R2 unchanged");
    wr(1, 12'h010, 2'd2, 32'hA5A5_0001, 0, "R5 write");
    idle();
    check32({31'b0, respErrEn}, 32'd1, "R5 respErrEn");
    // R3 lane and size selection
    rd(1, 12'h010, 2'd2, 32'hA5A5_0001, 0, "R5 readback");
    rd(1, 12'h013, 2'd0, 32'h0000_00A5, 0, "R3 byte lane3");
    rd(1, 12'h012, 2'd1, 32'h0000_A5A5, 0, "R3 half lane2");
    rd(1, 12'h011, 2'd1, 32'h0000_A500, 0, "R3 half lane1");
    rd(1, 12'h010, 2'd3, 32'hA5A5_0001, 0, "R3 size3 word");

    // R6 masked enables
    wr(1, 12'h028, 2'd2, 32'hFFFF_FFFF, 0, "R6 en write");
    wr(1, 12'h048, 2'd2, 32'hFFFF_FFFF, 0, "R6 brg write");
    idle();
    check32(ppcIntEn, 32'h00F0_00F3, "R6 ppcIntEn");
    rd(1, 12'h028, 2'd2, 32'h00F0_00F3, 0, "R6 en read");
    rd(1, 12'h048, 2'd2, 32'hFFFF_0000, 0, "R6 brg read");

    // R7 status registers
    rd(1, 12'h01C, 2'd2, 32'h0003_0001, 0, "R7 mpc status");
    rd(1, 12'h020, 2'd2, 32'h1234_5678, 0, "R7 ppc status");
    wr(1, 12'h020, 2'd2, 32'h0, 1, "R7 status write");
    rd(1, 12'h020, 2'd2, 32'h1234_5678, 0, "R7 status kept");

    // R8 clear pulse
    wr(1, 12'h024, 2'd2, 32'h0000_0013, 0, "R8 clear write");
    idle();
    check32(ppcIntClr, 32'h13, "R8 pulse high");
    idle();
    check32(ppcIntClr, 32'h0, "R8 pulse gone");
    rd(1, 12'h024, 2'd2, 32'h0, 1, "R8 clear read");

    // R9 per-PPC masks in the secure window
    wr(1, 12'h060, 2'd2, 32'hFFFF_000F, 0, "R9 ns ahbx0");
    wr(1, 12'h074, 2'd2, 32'h0000_8001, 0, "R9 ns apb1");
    wr(1, 12'h078, 2'd2, 32'h0000_FFFF, 1, "R9 apb slot2 unmapped");
    wr(1, 12'h08C, 2'd2, 32'h0000_C000, 0, "R9 ns apbx3");
    wr(1, 12'h0A0, 2'd2, 32'h0000_00FF, 0, "R9 sp ahbx0");
    wr(1, 12'h060, 2'd0, 32'h0000_00FF, 1, "R2 narrow mask write");
    idle();
    check32({16'b0, ppcNonSec[15:0]}, 32'h000F, "R9 nonsec idx0");
    check32({16'b0, ppcNonSec[95:80]}, 32'h8001, "R9 nonsec idx5");
    check32({16'b0, ppcNonSec[159:144]}, 32'hC000, "R9 nonsec idx9");
    rd(1, 12'h060, 2'd2, 32'h0000_000F, 0, "R9 ns read");
    rd(1, 12'h0A0, 2'd2, 32'h0000_00FF, 0, "R9 sp read");

    // R10 non-secure window
    wr(0, 12'h0A0, 2'd2, 32'h0000_0F0A, 0, "R10 nsp write");
    wr(0, 12'h000, 2'd2, 32'h0, 1, "R10 ns write callable");
    wr(0, 12'h060, 2'd2, 32'h0, 1, "R10 ns write mask");
    idle();
    check32({30'b0, cfgCallable}, 32'd3, "R10 callable kept");
    check32({16'b0, ppcNonSec[15:0]}, 32'h000F, "R10 nonsec kept");
    rd(0, 12'h0A0, 2'd2, 32'h0000_0F0A, 0, "R10 nsp read");
    rd(0, 12'h010, 2'd2, 32'h0, 1, "R10 resp hidden");
    rd(1, 12'h0A0, 2'd2, 32'h0000_00FF, 0, "R10 sp separate");

    // R11 privilege selection, then ns flip switching source in the same cycle
    idle();
    check32({16'b0, ppcPriv[15:0]}, 32'h00FA, "R11 priv mixed");
    wr(1, 12'h060, 2'd2, 32'h0000_00F0, 0, "R11 ns flip");
    idle();
    check32({16'b0, ppcNonSec[15:0]}, 32'h00F0, "R11 nonsec after flip");
    check32({16'b0, ppcPriv[15:0]}, 32'h000F, "R11 priv after flip");

    // R12 identification words
    rd(1, 12'hFD0, 2'd2, 32'h04, 0, "R12 id0");
    rd(1, 12'hFE0, 2'd2, 32'h52, 0, "R12 id secure");
    rd(0, 12'hFE0, 2'd2, 32'h53, 0, "R12 id nonsecure");
    rd(0, 12'hFE4, 2'd2, 32'hB8, 0, "R12 id5 nonsecure");
    rd(1, 12'hFFC, 2'd2, 32'hB1, 0, "R12 id last");
    wr(1, 12'hFE0, 2'd2, 32'hFF, 1, "R12 id write");
    rd(1, 12'hFE0, 2'd2, 32'h52, 0, "R12 id kept");

    // R13 unmapped
    rd(1, 12'h400, 2'd2, 32'h0, 1, "R13 read unmapped");
    wr(1, 12'h004, 2'd2, 32'hFFFF_FFFF, 1, "R13 write unmapped");
    rd(1, 12'h000, 2'd2, 32'h3, 0, "R13 neighbour kept");

    idle();
    repeat (3) @(negedge clk);
    check32(32'(expQ.size()), 32'd0, "scoreboard drained");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule